// File: doc/BRIEF.md
# Bar-Graph LCD Segment Controller

This block converts a 17-level thermometer code, produced by an external bank of voltage comparators, into drive for an 18-element bar-graph LCD with one common backplate. Three select inputs pick the display style. The styles are a single pointer bar, a pointer made of a pair of adjacent bars, and a filled thermometer column. In thermometer style the block can also keep a marker on the highest level seen since the last clear. That marker is cleared either on a repeating interval or on a short low pulse of the clear select.

All timing comes from a 1024 Hz tick qualifier on the system clock. The backplate is a 50% square wave with a period of 16 ticks. Each segment output is the backplate, or its complement when the segment is on, so every element sees zero net DC. The comparator code and the select inputs are taken into the display only at the tick that completes a frame. A segment therefore never changes polarity in the middle of a phase.

Top module: `bargraph_lcd_ctrl`

## Requirements
- R1: While `rst_n` is low, `bp_o` is 0, every `seg_o` bit is 0 and the peak marker is cleared.
- R2: `bp_o` advances only on cycles with `tick_i` high. It is low for 8 ticks and then high for 8 ticks, which gives a 16-tick period.
- R3: A segment that is on drives `seg_o[i] = ~bp_o`, and a segment that is off drives `seg_o[i] = bp_o`.
- R4: The display pattern is loaded only at the tick where `bp_o` falls, which ends a frame. Changes on `lvl_i` or on the selects at any other time do not affect `seg_o` until that tick.
- R5: The level index is h = 1 + the position of the highest set bit of `lvl_i`, and h = 0 when no bit is set. Bar index i (0-based) is `seg_o[i]`, so `lvl_i[j]` stands for bar j+1 and bar 0 is the element lit with no comparator tripped.
- R6: The mode is decoded from {disp, len, clr} = {`sel_disp_i`, `sel_len_i`, `sel_clr_i`}: 0,0,x gives single pointer; 0,1,x gives pair pointer; 1,0,x gives thermometer; 1,1,0 gives thermometer with interval-cleared peak; 1,1,1 gives thermometer with manually cleared peak. All-high is the default mode for floating selects.
- R7: In single-pointer mode exactly bar h is on.
- R8: In pair-pointer mode bars 2*(h/2) and 2*(h/2)+1 are on, and no others.
- R9: In thermometer mode bars 0 through h are on.
- R10: In both peak modes, bars 0..h are on, and so is the bar at the highest h taken at any frame end since the last clear.
- R11: In interval-clear mode, the peak is cleared at every 2048th tick counted while `sel_clr_i` stays low.
- R12: In a peak mode, a tick that sees `sel_clr_i` low after a tick that saw it high clears the peak. Outside the peak modes the peak is held at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick_i | input | 1 | 1024 Hz timing qualifier, one clock wide |
| lvl_i | input | 17 | Comparator outputs, bit j set when level j+1 is exceeded |
| sel_disp_i | input | 1 | Select: 0 pointer, 1 thermometer |
| sel_len_i | input | 1 | Select: pair pointer, or peak enable in thermometer style |
| sel_clr_i | input | 1 | Select: 1 manual clear, 0 interval clear; a low pulse clears |
| bp_o | output | 1 | Backplate drive |
| seg_o | output | 18 | Segment drives, bit 0 is the lowest bar |

## Verification
Every output bit is XOR-related to the backplate, so a wrong phase counter shows on all 19 pins at once, within one tick of the fault. A wrong display or peak register shows only after the next frame end, up to 16 ticks later. A peak timer that is off by a count shows only on the tick of the missed or early clear, about two seconds in. The stimulus therefore includes long runs with a held clear select and a marker parked above a low level, so that the clear is seen on the first frame after it.

// File: rtl/bgl_pkg.sv
package bgl_pkg;

  typedef enum logic [2:0] {
    MODE_PTR_ONE  = 3'd0,
    MODE_PTR_PAIR = 3'd1,
    MODE_THERMO   = 3'd2,
    MODE_PK_AUTO  = 3'd3,
    MODE_PK_MAN   = 3'd4
  } bar_mode_e;

  function automatic bar_mode_e decode_mode(input logic disp, input logic len,
                                            input logic clr);
    bar_mode_e m;
    if (!disp)      m = len ? MODE_PTR_PAIR : MODE_PTR_ONE;
    else if (!len)  m = MODE_THERMO;
    else            m = clr ? MODE_PK_MAN : MODE_PK_AUTO;
    return m;
  endfunction

endpackage

// File: rtl/bgl_phase_gen.sv
module bgl_phase_gen #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  output logic bp_o,
  output logic frame_o
);
  localparam int CW = $clog2(DIV);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (tick_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign bp_o    = cnt_q[CW-1];
  assign frame_o = tick_i && (cnt_q == CW'(DIV - 1));

  AST_BP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(bp_o)); // R2
  AST_FRAME_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    frame_o |=> $fell(bp_o)); // R4
endmodule

// File: rtl/bgl_level_enc.sv
module bgl_level_enc #(
  parameter int NUM_LVL = 17,
  parameter int IDX_W   = 5
) (
  input  logic [NUM_LVL-1:0] lvl_i,
  output logic [IDX_W-1:0]   idx_o
);
  always_comb begin
    idx_o = '0;
    for (int j = 0; j < NUM_LVL; j++) begin
      if (lvl_i[j]) idx_o = IDX_W'(j + 1);
    end
  end
endmodule

// File: rtl/bgl_peak_hold.sv
module bgl_peak_hold
  import bgl_pkg::*;
#(
  parameter int IDX_W      = 5,
  parameter int PEAK_TICKS = 2048
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             frame_i,
  input  bar_mode_e        mode_i,
  input  logic             sel_clr_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [IDX_W-1:0] pk_new_o
);
  localparam int TW = $clog2(PEAK_TICKS);

  logic [IDX_W-1:0] pk_q, pk_d, pk_base;
  logic [TW-1:0]    tmr_q, tmr_d;
  logic             clr_q, clr_d;
  logic             pk_en, is_auto, tmr_end, clr_hit;

  assign pk_en   = (mode_i == MODE_PK_AUTO) || (mode_i == MODE_PK_MAN);
  assign is_auto = (mode_i == MODE_PK_AUTO);
  assign tmr_end = (tmr_q == TW'(PEAK_TICKS - 1));
  assign clr_hit = pk_en && tick_i && ((!sel_clr_i && clr_q) || (is_auto && tmr_end));

  always_comb begin
    pk_base  = (!pk_en || clr_hit) ? '0 : pk_q;
    pk_new_o = pk_base;
    if (frame_i && idx_i > pk_base) pk_new_o = idx_i;
    pk_d  = pk_en ? pk_new_o : '0;
    tmr_d = tmr_q;
    clr_d = clr_q;
    if (tick_i) begin
      clr_d = sel_clr_i;
      if (!is_auto)     tmr_d = '0;
      else if (tmr_end) tmr_d = '0;
      else              tmr_d = tmr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pk_q  <= '0;
      tmr_q <= '0;
      clr_q <= 1'b1;
    end else begin
      pk_q  <= pk_d;
      tmr_q <= tmr_d;
      clr_q <= clr_d;
    end
  end

  AST_PEAK_MONOTONE: assert property (@(posedge clk) disable iff (!rst_n)
    (pk_en && !clr_hit) |=> pk_q >= $past(pk_q)); // R10
  AST_PEAK_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !pk_en |=> pk_q == '0); // R12
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit && !frame_i) |=> pk_q == '0); // R11
endmodule

// File: rtl/bgl_seg_map.sv
module bgl_seg_map
  import bgl_pkg::*;
#(
  parameter int NUM_BARS = 18,
  parameter int IDX_W    = 5
) (
  input  bar_mode_e         mode_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [IDX_W-1:0]  pk_i,
  output logic [NUM_BARS-1:0] on_o
);
  logic [IDX_W-1:0] pair_lo;
  assign pair_lo = {idx_i[IDX_W-1:1], 1'b0};

  always_comb begin
    on_o = '0;
    for (int i = 0; i < NUM_BARS; i++) begin
      unique case (mode_i)
        MODE_PTR_ONE:  on_o[i] = (IDX_W'(i) == idx_i);
        MODE_PTR_PAIR: on_o[i] = (IDX_W'(i) == pair_lo) || (IDX_W'(i) == pair_lo + 1'b1);
        MODE_THERMO:   on_o[i] = (IDX_W'(i) <= idx_i);
        MODE_PK_AUTO,
        MODE_PK_MAN:   on_o[i] = (IDX_W'(i) <= idx_i) || (IDX_W'(i) == pk_i);
        default:       on_o[i] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/bargraph_lcd_ctrl.sv
module bargraph_lcd_ctrl
  import bgl_pkg::*;
#(
  parameter int NUM_BARS   = 18,
  parameter int DRV_DIV    = 16,
  parameter int PEAK_TICKS = 2048
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick_i,
  input  logic [NUM_BARS-2:0]   lvl_i,
  input  logic                  sel_disp_i,
  input  logic                  sel_len_i,
  input  logic                  sel_clr_i,
  output logic                  bp_o,
  output logic [NUM_BARS-1:0]   seg_o
);
  localparam int NUM_LVL = NUM_BARS - 1;
  localparam int IDX_W   = $clog2(NUM_BARS);

  bar_mode_e             mode_w;
  logic                  frame_w;
  logic [IDX_W-1:0]      idx_w, pk_new_w;
  logic [NUM_BARS-1:0]   on_w, disp_q, disp_d;

  assign mode_w = decode_mode(sel_disp_i, sel_len_i, sel_clr_i);

  bgl_phase_gen #(.DIV(DRV_DIV)) u_phase (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .bp_o(bp_o), .frame_o(frame_w)
  );

  bgl_level_enc #(.NUM_LVL(NUM_LVL), .IDX_W(IDX_W)) u_enc (
    .lvl_i(lvl_i), .idx_o(idx_w)
  );

  bgl_peak_hold #(.IDX_W(IDX_W), .PEAK_TICKS(PEAK_TICKS)) u_peak (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .frame_i(frame_w),
    .mode_i(mode_w), .sel_clr_i(sel_clr_i), .idx_i(idx_w), .pk_new_o(pk_new_w)
  );

  bgl_seg_map #(.NUM_BARS(NUM_BARS), .IDX_W(IDX_W)) u_map (
    .mode_i(mode_w), .idx_i(idx_w), .pk_i(pk_new_w), .on_o(on_w)
  );

  always_comb begin
    disp_d = disp_q;
    if (frame_w) disp_d = on_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) disp_q <= '0;
    else        disp_q <= disp_d;
  end

  assign seg_o = disp_q ^ {NUM_BARS{bp_o}};

  AST_DISP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_w |=> $stable(seg_o ^ {NUM_BARS{bp_o}})); // R4
  AST_PTR_ONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_w && mode_w == MODE_PTR_ONE) |=> $countones(seg_o ^ {NUM_BARS{bp_o}}) == 1); // R7
  AST_PTR_PAIR_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_w && mode_w == MODE_PTR_PAIR) |=> $countones(seg_o ^ {NUM_BARS{bp_o}}) == 2); // R8
  AST_THERMO_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_w && mode_w != MODE_PTR_ONE && mode_w != MODE_PTR_PAIR) |=> seg_o[0] != bp_o); // R9
endmodule

// File: tb/tb_bargraph_lcd_ctrl.sv
module tb_bargraph_lcd_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 18;
  localparam int PK = 2048;

  logic          clk, rst_n, tick_i, sel_disp_i, sel_len_i, sel_clr_i, bp_o;
  logic [NB-2:0] lvl_i;
  logic [NB-1:0] seg_o;

  int checks, errors;
  bit done;

  int m_cnt, m_pk, m_t, m_mode_last;
  bit m_i3;
  logic [NB-1:0] m_disp;

  bargraph_lcd_ctrl dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .lvl_i(lvl_i),
    .sel_disp_i(sel_disp_i), .sel_len_i(sel_len_i), .sel_clr_i(sel_clr_i),
    .bp_o(bp_o), .seg_o(seg_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic int mode_of(input bit d, input bit l, input bit c);
    if (!d) return l ? 1 : 0;
    if (!l) return 2;
    return c ? 4 : 3;
  endfunction

  function automatic int hb(input logic [NB-2:0] v);
    int h = 0;
    for (int j = 0; j < NB - 1; j++) if (v[j]) h = j + 1;
    return h;
  endfunction

  function automatic logic [NB-1:0] pat(input int mode, input int h, input int pk);
    logic [NB-1:0] p = '0;
    for (int i = 0; i < NB; i++) begin
      case (mode)
        0: p[i] = (i == h);
        1: p[i] = (i / 2 == h / 2);
        2: p[i] = (i <= h);
        default: p[i] = (i <= h) || (i == pk);
      endcase
    end
    return p;
  endfunction

  function automatic string mtag(input int mode);
    case (mode)
      0: return "R3 R5 R6 R7";
      1: return "R3 R5 R6 R8";
      2: return "R3 R5 R6 R9";
      default: return "R3 R5 R6 R10";
    endcase
  endfunction

  task automatic check_vec(input string tag, input logic [NB-1:0] act, input logic [NB-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_cnt = 0; m_pk = 0; m_t = 0; m_i3 = 1'b1; m_disp = '0; m_mode_last = 4;
  endtask

  task automatic model_step();
    int mode, h, base, nw;
    bit pken, frame, clr;
    mode  = mode_of(sel_disp_i, sel_len_i, sel_clr_i);
    pken  = (mode >= 3);
    frame = tick_i && (m_cnt == 15);
    h     = hb(lvl_i);
    clr   = pken && tick_i && ((!sel_clr_i && m_i3) || (mode == 3 && m_t == PK - 1));
    base  = (!pken || clr) ? 0 : m_pk;
    nw    = (frame && h > base) ? h : base;
    if (frame) begin
      m_disp = pat(mode, h, nw);
      m_mode_last = mode;
    end
    m_pk = pken ? nw : 0;
    if (tick_i) begin
      m_t   = (mode == 3) ? ((m_t == PK - 1) ? 0 : m_t + 1) : 0;
      m_i3  = sel_clr_i;
      m_cnt = (m_cnt + 1) % 16;
    end
  endtask

  // one clock: inputs already set at negedge; model follows the edge; outputs compared at next negedge
  task automatic step();
    @(posedge clk);
    model_step();
    @(negedge clk);
    checks++;
    if (bp_o !== m_cnt[3]) begin
      errors++;
      $display("FAIL R2 bp actual=%b expected=%b", bp_o, m_cnt[3]);
    end
    check_vec(mtag(m_mode_last), seg_o, m_disp ^ {NB{m_cnt[3]}});
  endtask

  task automatic run(input int n, input bit tick_always);
    for (int k = 0; k < n; k++) begin
      tick_i = tick_always ? 1'b1 : ($urandom % 4 != 0);
      step();
    end
  endtask

  function automatic logic [NB-2:0] therm(input int k);
    return (k == 0) ? '0 : ((NB - 1)'((32'd1 << k) - 1));
  endfunction

  task automatic set_mode(input bit d, input bit l, input bit c);
    sel_disp_i = d; sel_len_i = l; sel_clr_i = c;
  endtask

  // drive ticks until the frame-ending tick has been applied
  task automatic to_frame_end();
    tick_i = 1'b1;
    do step(); while (m_cnt != 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [NB-1:0] held;
    checks = 0; errors = 0; done = 0;
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; tick_i = 1'b1; lvl_i = '1; set_mode(1, 1, 1);
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (bp_o !== 1'b0) begin errors++; $display("FAIL R1 bp actual=%b expected=0", bp_o); end
    check_vec("R1 seg", seg_o, '0);
    rst_n = 1'b1;

    // R7 R5: single pointer, nothing tripped -> bar 0
    set_mode(0, 0, 1); lvl_i = '0;
    to_frame_end();
    check_vec("R7 R5 zero level", seg_o ^ {NB{bp_o}}, 18'h00001);
    lvl_i = therm(17);
    to_frame_end();
    check_vec("R7 R5 full level", seg_o ^ {NB{bp_o}}, 18'h20000);

    // R4: mid-frame input change ignored
    held = seg_o ^ {NB{bp_o}};
    lvl_i = therm(3); set_mode(1, 0, 1);
    tick_i = 1'b0; step(); step();
    tick_i = 1'b1; step(); step();
    check_vec("R4 mid-frame hold", seg_o ^ {NB{bp_o}}, held);
    to_frame_end();
    check_vec("R4 R9 load at frame end", seg_o ^ {NB{bp_o}}, 18'h0000F);

    // R8: pair pointer corners
    set_mode(0, 1, 0); lvl_i = therm(17);
    to_frame_end();
    check_vec("R8 top pair", seg_o ^ {NB{bp_o}}, 18'h30000);
    lvl_i = therm(5);
    to_frame_end();
    check_vec("R8 pair of bar 5", seg_o ^ {NB{bp_o}}, 18'h00030);

    // R10 R12: manual peak hold and pulse clear
    set_mode(1, 1, 1); lvl_i = therm(12);
    to_frame_end();
    lvl_i = therm(2);
    to_frame_end();
    check_vec("R10 peak held", seg_o ^ {NB{bp_o}}, 18'h01007);
    tick_i = 1'b1; sel_clr_i = 1'b0; step(); sel_clr_i = 1'b1;
    to_frame_end();
    check_vec("R12 manual clear", seg_o ^ {NB{bp_o}}, 18'h00007);

    // R11: interval clear while clear select held low
    set_mode(1, 1, 0); lvl_i = therm(17);
    to_frame_end();
    lvl_i = '0;
    run(1000, 1'b1);
    to_frame_end();
    check_vec("R11 before interval", seg_o ^ {NB{bp_o}}, 18'h20001);
    run(1100, 1'b1);
    to_frame_end();
    check_vec("R11 after interval", seg_o ^ {NB{bp_o}}, 18'h00001);

    // random phases over all modes
    for (int ph = 0; ph < 40; ph++) begin
      case ($urandom % 5)
        0: set_mode(0, 0, $urandom % 2);
        1: set_mode(0, 1, $urandom % 2);
        2: set_mode(1, 0, $urandom % 2);
        3: set_mode(1, 1, 0);
        default: set_mode(1, 1, 1);
      endcase
      for (int k = 0; k < 200; k++) begin
        if ($urandom % 24 == 0)
          lvl_i = ($urandom % 4 == 0) ? (NB - 1)'($urandom) : therm($urandom % 18);
        if (sel_disp_i && sel_len_i && $urandom % 300 == 0) sel_clr_i = ~sel_clr_i;
        tick_i = ($urandom % 3 != 0);
        step();
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule